// File: doc/BRIEF.md
# Shared-RAM Subroutine Return Stack

This block keeps return addresses for a small microcontroller core whose program counter is 11 bits wide. It has no storage of its own for the stack. Each entry takes two bytes of the core's byte-wide data RAM, and all the entries sit in a fixed window of that RAM. A call strobe saves the current program counter. A subroutine-return strobe or an interrupt-return strobe takes back the newest entry and presents the address the core should load next.

The saved address is the program counter before any increment. On a subroutine return the block adds one before it hands the address back. On an interrupt return it hands the address back as stored. The pointer is three bits wide and wraps in both directions, so a ninth nested call overwrites the oldest entry without any warning.

A separate byte port reads and writes the whole RAM as ordinary indirect data, stack window included. Firmware can therefore use stack bytes it never reaches as plain variables.

Top module: `shared_ram_call_stack`

## Requirements
- R1: After reset the pointer is 0, `ret_valid_o` is 0, `ret_pc_o` is 0 and every RAM byte reads 0.
- R2: A call writes `pc_i` without incrementing it into entry n, where n is the pointer value before the call. PC bits 7:0 go to RAM byte 8+2n. PC bits 10:8 go to bits 2:0 of byte 9+2n, and bits 7:3 of that byte are written as 0. The pointer then advances by one.
- R3: A subroutine return first decrements the pointer and then reads that entry. One clock after the strobe, `ret_pc_o` equals the stored address plus one, wrapped to 11 bits so that 0x7FF gives 0x000. `ret_valid_o` is 1 in that cycle only.
- R4: An interrupt return pops in the same way, but `ret_pc_o` equals the stored address with nothing added.
- R5: Returns give back addresses in last-in first-out order across up to 8 nested calls. The pointer holds its value in a cycle with no strobe.
- R6: A call made with the pointer at 7 stores its entry in bytes 22/23 and wraps the pointer to 0. The next call then overwrites bytes 8/9, and the oldest entry is lost.
- R7: A return made with the pointer at 0 wraps the pointer to 7 and reads the entry in bytes 22/23.
- R8: With no strobe active, the data port writes `dat_wdata_i` to byte `dat_addr_i` on the clock edge when `dat_we_i` is 1. `dat_rdata_o` shows byte `dat_addr_i` combinationally. This works for all 64 bytes, including the stack window.
- R9: A data-port write in a cycle that has any stack strobe is ignored, and the addressed byte keeps its old value.
- R10: When several strobes arrive in one cycle, call takes priority over subroutine return, and subroutine return takes priority over interrupt return. Only the winning operation takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Push the current program counter |
| ret_i | input | 1 | Pop and return from subroutine (adds one) |
| reti_i | input | 1 | Pop and return from interrupt (no add) |
| pc_i | input | 11 | Program counter value to push |
| ret_pc_o | output | 11 | Address to load, valid one clock after a pop |
| ret_valid_o | output | 1 | Marks the cycle in which `ret_pc_o` is fresh |
| dat_addr_i | input | 6 | Byte address for the data port |
| dat_we_i | input | 1 | Data port write enable |
| dat_wdata_i | input | 8 | Data port write byte |
| dat_rdata_o | output | 8 | Data port read byte |

## Verification
The case hardest to reach from the ports is a wrapped pointer. The bench must first drain the stack to a known pointer of 0, then push nine distinct addresses, then pop past the bottom. This shows that bytes 8/9 now hold the ninth address and that the pop after that returns the entry in bytes 22/23. Directed sequences handle that, the 0x7FF increment wrap and collisions between a data write and a strobe. A long seeded random mix of calls, both kinds of return, data writes and reads then compares every return and every read byte against a bench model of the RAM and pointer.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_PUSH    = 2'd1,
    OP_POP_SUB = 2'd2,
    OP_POP_INT = 2'd3
  } stk_op_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             reti_i,
  output stk_op_e          op_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic [PTR_W-1:0] rd_slot_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  stk_op_e op;

  // fixed priority: call > ret > reti
  always_comb begin
    if (call_i)      op = OP_PUSH;
    else if (ret_i)  op = OP_POP_SUB;
    else if (reti_i) op = OP_POP_INT;
    else             op = OP_IDLE;
  end

  always_comb begin
    unique case (op)
      OP_PUSH:                ptr_d = ptr_q + 1'b1;
      OP_POP_SUB, OP_POP_INT: ptr_d = ptr_q - 1'b1;
      default:                ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign op_o      = op;
  assign ptr_o     = ptr_q;
  assign wr_slot_o = ptr_q;
  assign rd_slot_o = ptr_q - 1'b1;
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int PC_W       = 11,
  parameter int RAM_BYTES  = 64,
  parameter int STK_BASE   = 8,
  parameter int STK_LEVELS = 8,
  parameter int AW         = 6,
  parameter int PTR_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             stk_busy_i,
  input  logic [PTR_W-1:0] wr_slot_i,
  input  logic [PTR_W-1:0] rd_slot_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [AW-1:0]    dat_addr_i,
  input  logic             dat_we_i,
  input  logic [7:0]       dat_wdata_i,
  output logic [7:0]       dat_rdata_o,
  output logic [PC_W-1:0]  pop_pc_o
);
  localparam int HI_W  = PC_W - 8;
  localparam int PAD_W = 8 - HI_W;

  logic [7:0]    mem_q [RAM_BYTES];
  logic [AW-1:0] wr_lo, wr_hi, rd_lo, rd_hi;
  logic [7:0]    lo_byte, hi_byte;
  logic          dat_wr_ok;

  assign wr_lo     = AW'(STK_BASE + 2 * int'(wr_slot_i));
  assign wr_hi     = wr_lo + 1'b1;
  assign rd_lo     = AW'(STK_BASE + 2 * int'(rd_slot_i));
  assign rd_hi     = rd_lo + 1'b1;
  assign lo_byte   = pc_i[7:0];
  assign hi_byte   = {{PAD_W{1'b0}}, pc_i[PC_W-1:8]};
  assign dat_wr_ok = dat_we_i && !stk_busy_i;

  for (genvar b = 0; b < RAM_BYTES; b++) begin : g_byte
    if (b >= STK_BASE && b < STK_BASE + 2 * STK_LEVELS) begin : g_stk
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    mem_q[b] <= '0;
        else if (push_i && wr_lo == AW'(b))             mem_q[b] <= lo_byte;
        else if (push_i && wr_hi == AW'(b))             mem_q[b] <= hi_byte;
        else if (dat_wr_ok && dat_addr_i == AW'(b))     mem_q[b] <= dat_wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                mem_q[b] <= '0;
        else if (dat_wr_ok && dat_addr_i == AW'(b)) mem_q[b] <= dat_wdata_i;
      end
    end
  end

  assign dat_rdata_o = mem_q[dat_addr_i];
  assign pop_pc_o    = {mem_q[rd_hi][HI_W-1:0], mem_q[rd_lo]};
endmodule

// File: rtl/ras_ret.sv
module ras_ret #(
  parameter int PC_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic            inc_i,
  input  logic [PC_W-1:0] pop_pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            ret_valid_o
);
  logic [PC_W-1:0] ret_pc_q;
  logic            valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_pc_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= pop_i;
      if (pop_i) ret_pc_q <= inc_i ? pop_pc_i + 1'b1 : pop_pc_i;
    end
  end

  assign ret_pc_o    = ret_pc_q;
  assign ret_valid_o = valid_q;
endmodule

// File: rtl/shared_ram_call_stack.sv
module shared_ram_call_stack
  import ras_pkg::*;
#(
  parameter int PC_W       = 11,
  parameter int RAM_BYTES  = 64,
  parameter int STK_BASE   = 8,
  parameter int STK_LEVELS = 8,
  localparam int AW        = $clog2(RAM_BYTES),
  localparam int PTR_W     = $clog2(STK_LEVELS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            ret_valid_o,
  input  logic [AW-1:0]   dat_addr_i,
  input  logic            dat_we_i,
  input  logic [7:0]      dat_wdata_i,
  output logic [7:0]      dat_rdata_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] ptr_q, wr_slot, rd_slot;
  logic [PC_W-1:0]  pop_pc;
  logic             push, pop, stk_busy;

  assign push     = (op == OP_PUSH);
  assign pop      = (op == OP_POP_SUB) || (op == OP_POP_INT);
  assign stk_busy = (op != OP_IDLE);

  ras_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .reti_i    (reti_i),
    .op_o      (op),
    .ptr_o     (ptr_q),
    .wr_slot_o (wr_slot),
    .rd_slot_o (rd_slot)
  );

  ras_mem #(
    .PC_W(PC_W), .RAM_BYTES(RAM_BYTES), .STK_BASE(STK_BASE),
    .STK_LEVELS(STK_LEVELS), .AW(AW), .PTR_W(PTR_W)
  ) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .stk_busy_i  (stk_busy),
    .wr_slot_i   (wr_slot),
    .rd_slot_i   (rd_slot),
    .pc_i        (pc_i),
    .dat_addr_i  (dat_addr_i),
    .dat_we_i    (dat_we_i),
    .dat_wdata_i (dat_wdata_i),
    .dat_rdata_o (dat_rdata_o),
    .pop_pc_o    (pop_pc)
  );

  ras_ret #(.PC_W(PC_W)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop),
    .inc_i       (op == OP_POP_SUB),
    .pop_pc_i    (pop_pc),
    .ret_pc_o    (ret_pc_o),
    .ret_valid_o (ret_valid_o)
  );
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int PC_W  = 11,
  parameter int PTR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             call_i,
  input logic             ret_i,
  input logic             reti_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [PC_W-1:0]  pop_pc_i,
  input logic [PC_W-1:0]  ret_pc_o,
  input logic             ret_valid_o
);
  assert_push_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> ptr_i == PTR_W'($past(ptr_i) + 1'b1));

  assert_pop_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && (ret_i || reti_i)) |=> ptr_i == PTR_W'($past(ptr_i) - 1'b1));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(call_i || ret_i || reti_i) |=> $stable(ptr_i));

  assert_sub_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && ret_i) |=> ret_valid_o && ret_pc_o == PC_W'($past(pop_pc_i) + 1'b1));

  assert_int_raw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!call_i && !ret_i && reti_i) |=> ret_valid_o && ret_pc_o == $past(pop_pc_i));

  assert_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i || !(ret_i || reti_i)) |=> !ret_valid_o);
endmodule

bind shared_ram_call_stack ras_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .reti_i      (reti_i),
  .ptr_i       (ptr_q),
  .pop_pc_i    (pop_pc),
  .ret_pc_o    (ret_pc_o),
  .ret_valid_o (ret_valid_o)
);

// File: tb/shared_ram_call_stack_bench.sv
`timescale 1ns/1ps
module shared_ram_call_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call, ret, reti, dwe;
  logic [10:0] pc;
  logic [5:0]  daddr;
  logic [7:0]  dwdata;
  logic [10:0] ret_pc;
  logic        ret_valid;
  logic [7:0]  drdata;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mram [64];
  logic [2:0] mptr;

  always #5 clk = ~clk;

  shared_ram_call_stack u_shared_ram_call_stack (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret), .reti_i(reti),
    .pc_i(pc), .ret_pc_o(ret_pc), .ret_valid_o(ret_valid),
    .dat_addr_i(daddr), .dat_we_i(dwe), .dat_wdata_i(dwdata), .dat_rdata_o(drdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void mpush(input logic [10:0] v);
    mram[8 + 2 * int'(mptr)] = v[7:0];
    mram[9 + 2 * int'(mptr)] = {5'b0, v[10:8]};
    mptr = mptr + 3'd1;
  endfunction

  function automatic logic [10:0] mpop();
    mptr = mptr - 3'd1;
    return {mram[9 + 2 * int'(mptr)][2:0], mram[8 + 2 * int'(mptr)]};
  endfunction

  // drive at negedge, apply one edge, check at the following negedge
  task automatic step(input bit c, input bit r, input bit ri, input logic [10:0] p,
                      input bit we, input logic [5:0] a, input logic [7:0] wd,
                      input string tag);
    logic [10:0] exp_pc;
    bit popd;
    call = c; ret = r; reti = ri; pc = p; dwe = we; daddr = a; dwdata = wd;
    popd = 1'b0; exp_pc = '0;
    if (c) mpush(p);
    else if (r) begin exp_pc = mpop() + 11'd1; popd = 1'b1; end
    else if (ri) begin exp_pc = mpop(); popd = 1'b1; end
    else if (we) mram[a] = wd;
    @(posedge clk);
    @(negedge clk);
    call = 0; ret = 0; reti = 0; dwe = 0;
    chk(ret_valid == popd, tag, int'(ret_valid), int'(popd));
    if (popd) chk(ret_pc == exp_pc, tag, int'(ret_pc), int'(exp_pc));
    chk(drdata == mram[a], tag, int'(drdata), int'(mram[a]));
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    step(0, 0, 0, 11'h0, 0, a, 8'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] seq [9];
    void'($urandom(32'd4242));
    call = 0; ret = 0; reti = 0; dwe = 0; pc = '0; daddr = '0; dwdata = '0;
    for (int i = 0; i < 64; i++) mram[i] = 8'h00;
    mptr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ret_valid == 1'b0, "R1", int'(ret_valid), 0);
    chk(ret_pc == 11'h0, "R1", int'(ret_pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      daddr = 6'(i);
      #1 chk(drdata == 8'h00, "R1", int'(drdata), 0);
    end
    // R2 push stores raw pc in two bytes
    step(1, 0, 0, 11'h123, 0, 6'd8, 8'h0, "R2");
    step(1, 0, 0, 11'h7FF, 0, 6'd9, 8'h0, "R2");
    rd(6'd10, "R2");
    rd(6'd11, "R2");
    chk(drdata == 8'h07, "R2", int'(drdata), 8'h07);
    // R3 subroutine return with 11-bit wrap, R4 interrupt return raw
    step(0, 1, 0, 11'h0, 0, 6'd0, 8'h0, "R3");
    chk(ret_pc == 11'h000, "R3", int'(ret_pc), 0);
    step(0, 0, 1, 11'h0, 0, 6'd0, 8'h0, "R4");
    chk(ret_pc == 11'h123, "R4", int'(ret_pc), 11'h123);
    // R8 plain data access, including stack window bytes
    step(0, 0, 0, 11'h0, 1, 6'd20, 8'hA5, "R8");
    step(0, 0, 0, 11'h0, 1, 6'd40, 8'h3C, "R8");
    rd(6'd20, "R8");
    rd(6'd40, "R8");
    // R9 data write collides with a call: dropped
    step(1, 0, 0, 11'h055, 1, 6'd50, 8'hEE, "R9");
    chk(drdata == 8'h00, "R9", int'(drdata), 0);
    step(0, 0, 1, 11'h0, 1, 6'd51, 8'h77, "R9");
    chk(drdata == 8'h00, "R9", int'(drdata), 0);
    // R10 priority: call beats ret, ret beats reti
    step(1, 1, 1, 11'h2AA, 0, 6'd8, 8'h0, "R10");
    step(0, 1, 1, 11'h0, 0, 6'd0, 8'h0, "R10");
    chk(ret_pc == 11'h2AB, "R10", int'(ret_pc), 11'h2AB);
    // R6 overflow: from pointer 0 push nine, ninth lands in bytes 8/9
    while (mptr != 3'd0) step(0, 0, 1, 11'h0, 0, 6'd0, 8'h0, "R5");
    for (int i = 0; i < 9; i++) begin
      seq[i] = 11'(11'h100 + 37 * i);
      step(1, 0, 0, seq[i], 0, 6'(8 + 2 * (i % 8)), 8'h0, "R6");
    end
    rd(6'd8, "R6");
    chk(drdata == seq[8][7:0], "R6", int'(drdata), int'(seq[8][7:0]));
    step(0, 0, 1, 11'h0, 0, 6'd0, 8'h0, "R6");
    chk(ret_pc == seq[8], "R6", int'(ret_pc), int'(seq[8]));
    // R7 underflow: pop at pointer 0 reads bytes 22/23
    step(0, 0, 1, 11'h0, 0, 6'd22, 8'h0, "R7");
    chk(ret_pc == seq[7], "R7", int'(ret_pc), int'(seq[7]));
    // R5 remaining entries come back newest first
    for (int i = 6; i >= 1; i--) begin
      step(0, 0, 1, 11'h0, 0, 6'd0, 8'h0, "R5");
      chk(ret_pc == seq[i], "R5", int'(ret_pc), int'(seq[i]));
    end
    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [10:0] rp;
      logic [5:0] ra;
      logic [7:0] rw;
      bit rwe;
      k  = int'($urandom % 10);
      rp = 11'($urandom);
      ra = 6'($urandom);
      rw = 8'($urandom);
      rwe = ($urandom % 4) == 0;
      case (k)
        0, 1, 2: step(1, 0, 0, rp, rwe, ra, rw, "R2");
        3, 4:    step(0, 1, 0, rp, rwe, ra, rw, "R3");
        5:       step(0, 0, 1, rp, rwe, ra, rw, "R4");
        6, 7:    step(0, 0, 0, rp, 1, ra, rw, "R8");
        8:       step(1, ($urandom % 2) == 1, 1, rp, rwe, ra, rw, "R10");
        default: step(0, 0, 0, rp, 0, ra, rw, "R5");
      endcase
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule